// File: doc/BRIEF.md
# Root Port Reset Sequencer

This block takes a PCIe root port out of reset in a fixed order and then watches the link. Its output is a 16-bit reset control word. Every reset in it is active low: bit 0 is the PHY reset, bit 1 the PIPE reset, bit 2 the MAC reset, bit 3 the configuration-space reset and bit 8 the endpoint PERST. Bits 15:13 show that link-down auto-reset is enabled. A start pulse first holds every reset low. The four internal resets are then released together after a short wait, and PERST after a long wait. The block then waits, with a time limit, for the link-up indication from the link training logic.

Once the link is up, a drop of the link returns the sequencer to waiting for link-up. If auto-reset was requested at start, the drop also pulls the MAC and configuration resets low for a fixed number of cycles. The PHY, PIPE and PERST resets stay released during that pulse. All wait lengths are parameters given in clock cycles. If link-up does not arrive in time, the sequencer stops in a fail state and raises an error flag that only reset clears.

Top module: `rp_reset_seq`

## Requirements
- R1: While rst_n is low and in the cycle after it, rst_ctrl is 0x0000, seq_state is 0 (idle), link_ready is 0 and link_err is 0.
- R2: A start accepted in idle (0) or fail (8) gives exactly one cycle of state 1 with rst_ctrl = 0x0000. autorst_en is sampled together with that start.
- R3: State 2 (short wait) lasts exactly SHORT_CYC cycles. During it bits 3:0 and 8 are 0, and bits 15:13 all equal the sampled autorst_en.
- R4: State 3 (core release) lasts one cycle and is followed by state 4 (long wait) for exactly LONG_CYC cycles. In both states bits 3:0 are 1 and bit 8 is 0.
- R5: State 5 (PERST release) lasts one cycle with bit 8 set and leads to state 6 (link wait). Bit 8 is never 1 while bit 0 is 0.
- R6: In state 6, link_up high moves the sequencer to state 7 (link_ready = 1) on the next cycle. After LINK_TMO_CYC cycles without link_up it moves to state 8 instead. link_up wins in the last cycle of the wait. From state 8 on, link_err stays 1 until rst_n.
- R7: In state 7 with auto-reset sampled as 1, link_up low drives bits 2 and 3 to 0 for exactly PULSE_CYC cycles starting the next cycle, and the state returns to 6. Bits 0, 1 and 8 stay 1 during the pulse.
- R8: In state 7 with auto-reset sampled as 0, a link drop returns the state to 6 and leaves rst_ctrl unchanged at 0x010F.
- R9: start has no effect in states 1 to 7.
- R10: Bits 12:9 and 7:4 of rst_ctrl are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin or restart the sequence (idle or fail only) |
| autorst_en | input | 1 | Request link-down auto-reset, sampled with start |
| link_up | input | 1 | Link-up indication from the link training logic |
| rst_ctrl | output | 16 | Reset control word, active-low reset bits |
| seq_state | output | 4 | Current sequencer state code |
| link_ready | output | 1 | High while the link is up and supervised |
| link_err | output | 1 | Sticky link-up timeout flag |

## Verification
The sequence is run three ways. The first run has auto-reset enabled and link-up arriving mid-window. The second has no link-up at all, which ends in a timeout. The third restarts from fail with auto-reset disabled and link-up arriving in the very last window cycle. These runs separate the timeout priority, the ldr bits and the sticky error. Link drops are applied once with auto-reset on and once with it off. One drop is a single-cycle glitch that recovers during the pulse, and another is sustained. This shows that the pulse length does not depend on how long the drop lasts, and that only the MAC and configuration bits move. A start issued during the long wait confirms that a running sequence ignores it.

// File: rtl/rp_seq_pkg.sv
// Shared definitions for the root port reset sequencer.
// Assumes a 16-bit reset control word whose bit positions are fixed by the
// consumer that decodes it.
package rp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE          = 4'd0,
        ST_ALL_RESET     = 4'd1,
        ST_WAIT_SHORT    = 4'd2,
        ST_RELEASE_CORE  = 4'd3,
        ST_WAIT_LONG     = 4'd4,
        ST_RELEASE_PERST = 4'd5,
        ST_WAIT_LINK     = 4'd6,
        ST_LINK_UP       = 4'd7,
        ST_FAIL          = 4'd8
    } seq_st_e;

    localparam int CTRL_W    = 16;
    localparam int B_PHY     = 0;
    localparam int B_PIPE    = 1;
    localparam int B_MAC     = 2;
    localparam int B_CFG     = 3;
    localparam int B_PERST   = 8;
    localparam int B_LDR_LO  = 13;
    localparam int B_LDR_HI  = 15;
    localparam int LDR_W     = B_LDR_HI - B_LDR_LO + 1;

endpackage

// File: rtl/rp_step_timer.sv
// Step timer: counts cycles spent in the current sequencer state.
// Assumes clr is raised in the cycle before a state change, so the count
// reads 0 in the first cycle of every state. Saturates at its maximum.
module rp_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    // Count up, restart on clear, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/rp_drop_guard.sv
// Link-drop guard: while armed, a low link_up starts a pulse of PULSE_CYC
// cycles (from the next cycle) during which MAC and configuration resets
// are pulled low. A new drop while armed restarts the pulse.
// Assumes PULSE_CYC >= 1.
module rp_drop_guard #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic link_up,
    output logic active
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC);

    logic [PW-1:0] left;
    logic          trig;

    assign trig   = armed && !link_up;
    assign active = (left != '0);

    // Load the pulse length on a drop, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          left <= '0;
        else if (trig)       left <= PULSE_LOAD;
        else if (left != '0) left <= left - 1'b1;
    end

    a_r7_drop_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active);
    a_r7_pulse_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(armed) && !$past(link_up));
endmodule

// File: rtl/rp_seq_ctrl.sv
// Sequencer state machine: steps through full reset, short wait, core
// release, long wait, PERST release and the link wait, then supervises the
// link. Assumes every wait length is at least 1 and fits in CW bits.
module rp_seq_ctrl
    import rp_seq_pkg::*;
#(
    parameter int SHORT_CYC    = 4,
    parameter int LONG_CYC     = 8,
    parameter int LINK_TMO_CYC = 8,
    parameter int CW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          autorst_en,
    input  logic          link_up,
    input  logic [CW-1:0] cnt,
    output seq_st_e       state,
    output logic          timer_clr,
    output logic          ldr_q,
    output logic          err
);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST   = CW'(LINK_TMO_CYC - 1);

    seq_st_e nxt;
    logic    start_ok;

    assign start_ok  = start && (state == ST_IDLE || state == ST_FAIL);
    assign timer_clr = (nxt != state);

    // Next-state selection; link_up takes priority over the timeout.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:          if (start) nxt = ST_ALL_RESET;
            ST_ALL_RESET:     nxt = ST_WAIT_SHORT;
            ST_WAIT_SHORT:    if (cnt == SHORT_LAST) nxt = ST_RELEASE_CORE;
            ST_RELEASE_CORE:  nxt = ST_WAIT_LONG;
            ST_WAIT_LONG:     if (cnt == LONG_LAST) nxt = ST_RELEASE_PERST;
            ST_RELEASE_PERST: nxt = ST_WAIT_LINK;
            ST_WAIT_LINK: begin
                if (link_up)               nxt = ST_LINK_UP;
                else if (cnt == TMO_LAST)  nxt = ST_FAIL;
            end
            ST_LINK_UP:       if (!link_up) nxt = ST_WAIT_LINK;
            ST_FAIL:          if (start) nxt = ST_ALL_RESET;
            default:          nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Sample the auto-reset request with an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)        ldr_q <= 1'b0;
        else if (start_ok) ldr_q <= autorst_en;
    end

    // Sticky timeout flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     err <= 1'b0;
        else if (state == ST_WAIT_LINK && nxt == ST_FAIL) err <= 1'b1;
    end

    a_r2_full_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALL_RESET) |=> (state == ST_WAIT_SHORT));
    a_r3_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SHORT && cnt != SHORT_LAST) |=> (state == ST_WAIT_SHORT));
    a_r4_long_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_LONG && cnt != LONG_LAST) |=> (state == ST_WAIT_LONG));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r6_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_LINK && link_up) |=> (state == ST_LINK_UP));
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_WAIT_LONG && cnt != LONG_LAST) |=> (state == ST_WAIT_LONG));
endmodule

// File: rtl/rp_reset_seq.sv
// Root port reset sequencer top: combines the state machine, the step timer
// and the link-drop guard, and decodes the active-low reset control word.
// Assumes link_up is already synchronous to clk.
module rp_reset_seq
    import rp_seq_pkg::*;
#(
    parameter int SHORT_CYC    = 50000,
    parameter int LONG_CYC     = 10000000,
    parameter int LINK_TMO_CYC = 10000000,
    parameter int PULSE_CYC    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        autorst_en,
    input  logic        link_up,
    output logic [15:0] rst_ctrl,
    output logic [3:0]  seq_state,
    output logic        link_ready,
    output logic        link_err
);
    localparam int MAX_A   = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int MAX_CYC = (MAX_A > LINK_TMO_CYC) ? MAX_A : LINK_TMO_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    seq_st_e       state;
    logic [CW-1:0] cnt;
    logic          timer_clr;
    logic          ldr_q;
    logic          pulse;
    logic          core_on;
    logic          perst_on;
    logic          ldr_on;

    rp_seq_ctrl #(
        .SHORT_CYC    (SHORT_CYC),
        .LONG_CYC     (LONG_CYC),
        .LINK_TMO_CYC (LINK_TMO_CYC),
        .CW           (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .autorst_en (autorst_en),
        .link_up    (link_up),
        .cnt        (cnt),
        .state      (state),
        .timer_clr  (timer_clr),
        .ldr_q      (ldr_q),
        .err        (link_err)
    );

    rp_step_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .cnt   (cnt)
    );

    rp_drop_guard #(.PULSE_CYC(PULSE_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (state == ST_LINK_UP && ldr_q),
        .link_up (link_up),
        .active  (pulse)
    );

    // Which groups of resets are released in the current state.
    always_comb begin
        core_on  = (state == ST_RELEASE_CORE) || (state == ST_WAIT_LONG) ||
                   (state == ST_RELEASE_PERST) || (state == ST_WAIT_LINK) ||
                   (state == ST_LINK_UP) || (state == ST_FAIL);
        perst_on = (state == ST_RELEASE_PERST) || (state == ST_WAIT_LINK) ||
                   (state == ST_LINK_UP) || (state == ST_FAIL);
        ldr_on   = ldr_q && (state != ST_IDLE) && (state != ST_ALL_RESET);
    end

    // Assemble the control word; the drop pulse masks MAC and config only.
    always_comb begin
        rst_ctrl                    = '0;
        rst_ctrl[B_PHY]             = core_on;
        rst_ctrl[B_PIPE]            = core_on;
        rst_ctrl[B_MAC]             = core_on && !pulse;
        rst_ctrl[B_CFG]             = core_on && !pulse;
        rst_ctrl[B_PERST]           = perst_on;
        rst_ctrl[B_LDR_HI:B_LDR_LO] = {LDR_W{ldr_on}};
    end

    assign seq_state  = state;
    assign link_ready = (state == ST_LINK_UP);

    a_r5_perst_needs_phy: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ctrl[B_PERST] |-> rst_ctrl[B_PHY]);
    a_r7_pulse_keeps_phy_perst: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && state == ST_LINK_UP) |-> (rst_ctrl[B_PHY] && rst_ctrl[B_PIPE] && rst_ctrl[B_PERST]));
    a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ctrl[12:9] == 4'd0) && (rst_ctrl[7:4] == 4'd0));
endmodule

// File: tb/test_rp_reset_seq.sv
// Self-checking bench: a behavioural reference model steps alongside the
// design and every output is compared once per clock.
module test_rp_reset_seq;
    localparam int SHORT = 5;
    localparam int LONG  = 12;
    localparam int TMO   = 20;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        autorst_en = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] rst_ctrl;
    logic [3:0]  seq_state;
    logic        link_ready;
    logic        link_err;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // reference model state
    int m_st = 0, m_cnt = 0, m_pulse = 0;
    bit m_ldr = 0, m_err = 0;

    rp_reset_seq #(
        .SHORT_CYC(SHORT), .LONG_CYC(LONG), .LINK_TMO_CYC(TMO), .PULSE_CYC(PULSE)
    ) i_rp_reset_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .autorst_en(autorst_en),
        .link_up(link_up), .rst_ctrl(rst_ctrl), .seq_state(seq_state),
        .link_ready(link_ready), .link_err(link_err)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_ctrl();
        logic [15:0] w = '0;
        bit core  = (m_st >= 3 && m_st <= 8);
        bit perst = (m_st >= 5 && m_st <= 8);
        w[0] = core; w[1] = core;
        w[2] = core && (m_pulse == 0);
        w[3] = core && (m_pulse == 0);
        w[8] = perst;
        if (m_ldr && m_st != 0 && m_st != 1) w[15:13] = 3'b111;
        return w;
    endfunction

    function automatic string tag();
        if (m_pulse != 0) return "R7";
        case (m_st)
            0: return "R1";  1: return "R2";  2: return "R3";
            3, 4: return "R4"; 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Model step: follows the requirements, one clock at a time.
    always @(posedge clk) begin
        int nx;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pulse = 0; m_ldr = 0; m_err = 0;
        end else begin
            if (m_st == 7 && m_ldr && !link_up) m_pulse = PULSE;
            else if (m_pulse > 0)               m_pulse = m_pulse - 1;
            nx = m_st;
            case (m_st)
                0: if (start) nx = 1;
                1: nx = 2;
                2: if (m_cnt == SHORT - 1) nx = 3;
                3: nx = 4;
                4: if (m_cnt == LONG - 1) nx = 5;
                5: nx = 6;
                6: if (link_up) nx = 7; else if (m_cnt == TMO - 1) nx = 8;
                7: if (!link_up) nx = 6;
                8: if (start) nx = 1;
                default: nx = 0;
            endcase
            if ((m_st == 0 || m_st == 8) && start) m_ldr = autorst_en;
            if (nx == 8 && m_st == 6) m_err = 1;
            m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
            m_st = nx;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag(), 32'(rst_ctrl), 32'(exp_ctrl()), "rst_ctrl");
            check(tag(), 32'(seq_state), 32'(m_st), "seq_state");
            check("R6", 32'(link_ready), 32'(m_st == 7), "link_ready");
            check("R6", 32'(link_err), 32'(m_err), "link_err");
            check("R10", 32'({rst_ctrl[12:9], rst_ctrl[7:4]}), 32'd0, "spare bits");
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_st(input int s);
        for (int i = 0; i < 500 && m_st != s; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        tick(3);
        check("R1", 32'(rst_ctrl), 32'd0, "reset ctrl");
        check("R1", 32'(seq_state), 32'd0, "reset state");
        rst_n = 1'b1;
        tick(1);
        check("R1", 32'({link_ready, link_err}), 32'd0, "flags after reset");
        // run with auto-reset, link up mid-window
        autorst_en = 1'b1; start = 1'b1;
        tick(1);
        start = 1'b0; autorst_en = 1'b0;
        wait_st(4);
        tick(2);
        start = 1'b1;               // R9: must be ignored
        tick(1);
        start = 1'b0;
        check("R9", 32'(seq_state), 32'd4, "start during long wait");
        wait_st(6);
        tick(5);
        link_up = 1'b1;
        wait_st(7);
        tick(4);
        link_up = 1'b0;             // one-cycle glitch, recovers during pulse
        tick(1);
        link_up = 1'b1;
        tick(1);
        check("R7", 32'(rst_ctrl), 32'hE103, "pulse keeps phy/pipe/perst");
        tick(10);
        link_up = 1'b0;             // sustained drop, runs into timeout
        wait_st(8);
        tick(3);
        check("R6", 32'(link_err), 32'd1, "sticky err in fail");
        // restart from fail without auto-reset, link up in the last window cycle
        start = 1'b1;
        tick(1);
        start = 1'b0;
        check("R2", 32'(seq_state), 32'd1, "restart from fail");
        check("R6", 32'(link_err), 32'd1, "err survives restart");
        wait_st(6);
        tick(TMO - 1);
        link_up = 1'b1;
        tick(1);
        check("R6", 32'(seq_state), 32'd7, "link wins on last cycle");
        tick(3);
        link_up = 1'b0;
        tick(2);
        check("R8", 32'(rst_ctrl), 32'h010F, "drop without auto-reset");
        link_up = 1'b1;
        tick(4);
        check("R8", 32'(seq_state), 32'd7, "back to link up");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule